// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block sits between a simple request port and an asynchronous DRAM whose row and column addresses share one set of address pins. A request carries an 18-bit word address, a read/write flag and write data; the controller splits the address into a row half and a column half and drives the two halves onto the pins in turn. It opens a row with the row strobe and then performs one column access with the column strobe. All four DRAM control pins are active low. Every minimum timing figure is given in nanoseconds as a parameter and is turned into a whole number of clock cycles, rounded up.

After an access the row stays open. A following request to the same row skips the row phase and costs only a column cycle. A request to any other row first closes the open row and waits out the precharge time. A refresh timer raises a refresh request once per (refresh period / number of rows). Refresh takes precedence over new requests: the controller closes any open row and then performs a row-only dummy access to the next row in sequence.

Writes are always early writes. The write strobe and the data are set up before the column strobe falls, so the data pins stay in one direction for the whole column access. Reads return one byte through a one-cycle response pulse, and responses come back in request order.

Top module: `pagemode_dram_ctrl`

## Requirements
- R1: The row half stays on the address pins for at least one cycle before the row strobe falls and during the cycle in which it falls. The column half is held the same way around the column strobe falling edge.
- R2: The control pins are active low. During and after reset the row strobe, column strobe, write strobe and output enable are high, the data pins are not driven, and the request port is ready. The write strobe and the output enable are never low together.
- R3: Two row-strobe falling edges are at least T_RC cycles apart (ceil(110 ns / clock period), which is 11 at 10 ns).
- R4: Read data is captured no sooner than ceil(60 ns / clock) cycles after the row strobe falls and no sooner than ceil(15 ns / clock) cycles after the column strobe falls. It is returned with a single-cycle rsp_valid pulse, and responses come back in request order.
- R5: Two column-strobe falling edges are at least ceil(35 ns / clock) cycles apart, which is 4 at 10 ns.
- R6: The column strobe falls only while the row strobe is low. Consecutive requests to the same row share one row-strobe falling edge and use column cycles only.
- R7: Writes are early writes. The write strobe is low and the data pins are driven in the cycle before the column strobe falls, and both stay that way while the column strobe is low. The output enable stays high throughout.
- R8: A refresh cycle is a row-strobe pulse with no column strobe. One happens every REFRESH_NS / (2^PIN_W × clock period) cycles, give or take the length of one access. Refreshed rows go 0, 1, 2 and so on, wrapping at the last row.
- R9: While a refresh is pending or in progress, req_ready is low. Any open row is closed before the refresh row is opened.
- R10: Before the row strobe falls again, it has been high for at least ceil(40 ns / clock) cycles of precharge.
- R11: The row is req_addr[17:9] and the column is req_addr[8:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*PIN_W | Word address, row in upper half |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | PIN_W | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from the DRAM |

## Verification
The hardest case to reach is a refresh timer that expires while a row is open and a request is waiting. In that case the controller must hold off the request, close the row, run the refresh row and only then reopen a row. The bench shortens the refresh period to 400 cycles and runs a long stream of back-to-back requests over four rows, so refreshes land on every phase of an access. Page-hit and row-miss groups are started just after an observed refresh so that their row-strobe counts are exact. The DRAM model in the bench returns corrupted data until both access times have elapsed, so a read sampled a cycle early shows up as a data mismatch.

// File: rtl/pmdc_pkg.sv
// Shared types and helpers for the page-mode DRAM controller.
// Assumes all timing figures are positive integers in nanoseconds.
package pmdc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,   // row closed, strobes high
        S_ROW,    // row half on pins, waiting for precharge and row-cycle gap
        S_RASD,   // row strobe low, row half still held
        S_COL,    // column half on pins, waiting for column-cycle gap
        S_CAS,    // column strobe low
        S_OPEN,   // row open, column strobe high
        S_REFH    // refresh row held open
    } st_e;

    localparam int TI_RC   = 0;
    localparam int TI_RP   = 1;
    localparam int TI_PC   = 2;
    localparam int TI_RAC  = 3;
    localparam int TI_CAC  = 4;
    localparam int NUM_TMR = 5;

    // Nanoseconds to whole clock cycles, rounded up.
    function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/pmdc_gap_timer.sv
// Minimum-gap timer: load restarts a count of LOAD cycles; done is high once
// the count has run out. Assumes LOAD = required cycles minus one.
module pmdc_gap_timer #(
    parameter int unsigned LOAD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = (LOAD > 0) ? $clog2(LOAD + 1) : 1;

    logic [CW-1:0] cnt;

    // Count down to zero after each load, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= CW'(LOAD);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pmdc_refresh_timer.sv
// Refresh scheduler: raises pending every INTERVAL cycles and holds it until
// acknowledged; supplies the next row to refresh, advancing on each ack.
module pmdc_refresh_timer #(
    parameter int unsigned INTERVAL = 1562,
    parameter int unsigned ROW_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] row
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;

    // Free-running interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= CW'(INTERVAL - 1);
        else if (cnt == '0)  cnt <= CW'(INTERVAL - 1);
        else                 cnt <= cnt - 1'b1;
    end

    // Pending flag: a new tick wins over a same-cycle ack.
    always_ff @(posedge clk) begin
        if (!rst_n)          pending <= 1'b0;
        else if (cnt == '0)  pending <= 1'b1;
        else if (ack)        pending <= 1'b0;
    end

    // Row sequence for refresh, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)   row <= '0;
        else if (ack) row <= row + 1'b1;
    end
endmodule

// File: rtl/pagemode_dram_ctrl.sv
// Page-mode controller for an asynchronous DRAM with multiplexed row/column
// pins. Keeps one row open for page hits, closes it for misses and refresh.
// Assumes early writes only and a DRAM whose access times are met when the
// cycle counts derived from the ns parameters have elapsed.
module pagemode_dram_ctrl #(
    parameter int unsigned PIN_W      = 9,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CLK_NS     = 10,
    parameter int unsigned TRC_NS     = 110,
    parameter int unsigned TRAC_NS    = 60,
    parameter int unsigned TCAC_NS    = 15,
    parameter int unsigned TPC_NS     = 35,
    parameter int unsigned TRP_NS     = 40,
    parameter int unsigned REFRESH_NS = 8000000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [2*PIN_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [PIN_W-1:0]     dram_addr,
    output logic                 dram_ras_n,
    output logic                 dram_cas_n,
    output logic                 dram_we_n,
    output logic                 dram_oe_n,
    output logic [DATA_W-1:0]    dram_dq_out,
    output logic                 dram_dq_oe,
    input  logic [DATA_W-1:0]    dram_dq_in
);
    import pmdc_pkg::*;

    localparam int unsigned NUM_ROWS = 1 << PIN_W;
    localparam int unsigned REF_CYC  = REFRESH_NS / (NUM_ROWS * CLK_NS);

    // Timer reload value (required cycles minus one) per timer index.
    function automatic int unsigned tmr_load(int idx);
        int unsigned c;
        case (idx)
            TI_RC:   c = ns2cyc(TRC_NS,  CLK_NS);
            TI_RP:   c = ns2cyc(TRP_NS,  CLK_NS);
            TI_PC:   c = ns2cyc(TPC_NS,  CLK_NS);
            TI_RAC:  c = ns2cyc(TRAC_NS, CLK_NS);
            default: c = ns2cyc(TCAC_NS, CLK_NS);
        endcase
        return (c > 0) ? c - 1 : 0;
    endfunction

    st_e                 state;
    logic                is_ref;
    logic [PIN_W-1:0]    cur_row, cur_col;
    logic                cur_wr;
    logic [DATA_W-1:0]   cur_wdata;
    logic [NUM_TMR-1:0]  tmr_ld, tmr_done;
    logic                ref_pend, ref_ack;
    logic [PIN_W-1:0]    ref_row;
    logic                req_fire, page_hit;
    logic                ras_fall_go, ras_rise_go, cas_fall_go, cas_rise_go;
    logic [PIN_W-1:0]    req_row, req_col;

    assign req_row = req_addr[2*PIN_W-1:PIN_W];
    assign req_col = req_addr[PIN_W-1:0];

    // One gap timer per timing rule.
    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        pmdc_gap_timer #(.LOAD(tmr_load(g))) u_tmr (
            .clk  (clk),
            .rst_n(rst_n),
            .load (tmr_ld[g]),
            .done (tmr_done[g])
        );
    end

    pmdc_refresh_timer #(.INTERVAL(REF_CYC), .ROW_W(PIN_W)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack    (ref_ack),
        .pending(ref_pend),
        .row    (ref_row)
    );

    // Strobe edge decisions and request acceptance.
    always_comb begin
        req_ready   = (state == S_IDLE || state == S_OPEN) && !ref_pend;
        req_fire    = req_valid && req_ready;
        page_hit    = (req_row == cur_row);
        ras_fall_go = (state == S_ROW) && tmr_done[TI_RC] && tmr_done[TI_RP];
        cas_fall_go = (state == S_COL) && tmr_done[TI_PC];
        cas_rise_go = (state == S_CAS) && tmr_done[TI_CAC] && tmr_done[TI_RAC];
        ref_ack     = (state == S_REFH) && tmr_done[TI_RAC];
        ras_rise_go = ref_ack ||
                      ((state == S_OPEN) && (ref_pend || (req_fire && !page_hit)));
        tmr_ld            = '0;
        tmr_ld[TI_RC]     = ras_fall_go;
        tmr_ld[TI_RAC]    = ras_fall_go;
        tmr_ld[TI_RP]     = ras_rise_go;
        tmr_ld[TI_PC]     = cas_fall_go;
        tmr_ld[TI_CAC]    = cas_fall_go;
    end

    // Main sequencer: registers every pin driven toward the DRAM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            is_ref      <= 1'b0;
            cur_row     <= '0;
            cur_col     <= '0;
            cur_wr      <= 1'b0;
            cur_wdata   <= '0;
            dram_addr   <= '0;
            dram_ras_n  <= 1'b1;
            dram_cas_n  <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_dq_oe  <= 1'b0;
            dram_dq_out <= '0;
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (ref_pend) begin
                        is_ref    <= 1'b1;
                        dram_addr <= ref_row;
                        state     <= S_ROW;
                    end else if (req_fire) begin
                        is_ref    <= 1'b0;
                        cur_row   <= req_row;
                        cur_col   <= req_col;
                        cur_wr    <= req_write;
                        cur_wdata <= req_wdata;
                        dram_addr <= req_row;
                        state     <= S_ROW;
                    end
                end
                S_ROW: begin
                    if (ras_fall_go) begin
                        dram_ras_n <= 1'b0;
                        state      <= is_ref ? S_REFH : S_RASD;
                    end
                end
                S_RASD: begin
                    dram_addr   <= cur_col;
                    dram_we_n   <= !cur_wr;
                    dram_oe_n   <= cur_wr;
                    dram_dq_oe  <= cur_wr;
                    dram_dq_out <= cur_wdata;
                    state       <= S_COL;
                end
                S_COL: begin
                    if (cas_fall_go) begin
                        dram_cas_n <= 1'b0;
                        state      <= S_CAS;
                    end
                end
                S_CAS: begin
                    if (cas_rise_go) begin
                        dram_cas_n <= 1'b1;
                        dram_we_n  <= 1'b1;
                        dram_oe_n  <= 1'b1;
                        dram_dq_oe <= 1'b0;
                        if (!cur_wr) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= dram_dq_in;
                        end
                        state <= S_OPEN;
                    end
                end
                S_OPEN: begin
                    if (ref_pend) begin
                        dram_ras_n <= 1'b1;
                        state      <= S_IDLE;
                    end else if (req_fire && page_hit) begin
                        cur_col     <= req_col;
                        cur_wr      <= req_write;
                        cur_wdata   <= req_wdata;
                        dram_addr   <= req_col;
                        dram_we_n   <= !req_write;
                        dram_oe_n   <= req_write;
                        dram_dq_oe  <= req_write;
                        dram_dq_out <= req_wdata;
                        state       <= S_COL;
                    end else if (req_fire) begin
                        cur_row    <= req_row;
                        cur_col    <= req_col;
                        cur_wr     <= req_write;
                        cur_wdata  <= req_wdata;
                        dram_addr  <= req_row;
                        dram_ras_n <= 1'b1;
                        state      <= S_ROW;
                    end
                end
                S_REFH: begin
                    if (ref_ack) begin
                        dram_ras_n <= 1'b1;
                        is_ref     <= 1'b0;
                        state      <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pmdc_checker.sv
// Protocol checker for the DRAM pins of pagemode_dram_ctrl. Spacing rules
// are checked with saturating cycle counters rather than deep history.
module pmdc_checker #(
    parameter int unsigned PIN_W  = 9,
    parameter int unsigned CLK_NS = 10,
    parameter int unsigned TRC_NS = 110,
    parameter int unsigned TPC_NS = 35,
    parameter int unsigned TRP_NS = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rsp_valid,
    input logic [PIN_W-1:0] dram_addr,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_we_n,
    input logic             dram_oe_n,
    input logic             dram_dq_oe
);
    import pmdc_pkg::*;

    localparam int T_RC = int'(ns2cyc(TRC_NS, CLK_NS));
    localparam int T_PC = int'(ns2cyc(TPC_NS, CLK_NS));
    localparam int T_RP = int'(ns2cyc(TRP_NS, CLK_NS));

    logic prev_ras, prev_cas;
    int   rc_cnt, pc_cnt, rp_cnt;
    logic ras_fall, ras_rise, cas_fall;

    assign ras_fall = prev_ras && !dram_ras_n;
    assign ras_rise = !prev_ras && dram_ras_n;
    assign cas_fall = prev_cas && !dram_cas_n;

    // Previous strobe levels and cycles since each relevant edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ras <= 1'b1;
            prev_cas <= 1'b1;
            rc_cnt   <= T_RC;
            pc_cnt   <= T_PC;
            rp_cnt   <= T_RP;
        end else begin
            prev_ras <= dram_ras_n;
            prev_cas <= dram_cas_n;
            rc_cnt   <= ras_fall ? 1 : ((rc_cnt < T_RC) ? rc_cnt + 1 : rc_cnt);
            pc_cnt   <= cas_fall ? 1 : ((pc_cnt < T_PC) ? pc_cnt + 1 : pc_cnt);
            rp_cnt   <= ras_rise ? 1 : ((rp_cnt < T_RP) ? rp_cnt + 1 : rp_cnt);
        end
    end

    assert_row_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ras_fall |-> $stable(dram_addr));
    assert_col_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cas_fall |-> $stable(dram_addr));
    assert_we_oe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);
    assert_row_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ras_fall |-> rc_cnt >= T_RC);
    assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_col_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cas_fall |-> pc_cnt >= T_PC);
    assert_cas_in_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);
    assert_early_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_fall && !dram_we_n) |-> ($past(!dram_we_n) && dram_dq_oe));
    assert_precharge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ras_fall |-> rp_cnt >= T_RP);
endmodule

bind pagemode_dram_ctrl pmdc_checker #(
    .PIN_W (PIN_W),
    .CLK_NS(CLK_NS),
    .TRC_NS(TRC_NS),
    .TPC_NS(TPC_NS),
    .TRP_NS(TRP_NS)
) u_pmdc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .dram_addr (dram_addr),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n),
    .dram_we_n (dram_we_n),
    .dram_oe_n (dram_oe_n),
    .dram_dq_oe(dram_dq_oe)
);

// File: tb/pagemode_dram_ctrl_test.sv
// Bench: behavioural DRAM model with per-clock protocol and timing checks,
// plus a shadow memory and response queue for read data.
module pagemode_dram_ctrl_test;
    localparam int CLK_NS = 10;
    localparam int RC  = 11;   // ceil(110/10)
    localparam int RAC = 6;    // ceil(60/10)
    localparam int CAC = 2;    // ceil(15/10)
    localparam int PC  = 4;    // ceil(35/10)
    localparam int RP  = 4;    // ceil(40/10)
    localparam int REFC = 400; // 2048000 / (512*10)
    localparam int SLACK = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [8:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [7:0]  dram_dq_out;
    logic [7:0]  dram_dq_in = '0;

    pagemode_dram_ctrl #(.CLK_NS(CLK_NS), .REFRESH_NS(2048000)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // DRAM model state
    logic [7:0] dmem [int];
    logic [7:0] shadow [int];
    logic [7:0] exp_q [$];
    logic prev_ras = 1, prev_cas = 1, prev_we = 1;
    logic [8:0] prev_addr = '0;
    logic [8:0] open_row = '0;
    int ras_fall_cyc = -100, ras_rise_cyc = -100, cas_fall_cyc = -100;
    bit cas_seen = 0;
    int ras_falls = 0, nref = 0, last_ref_cyc = 0, exp_ref_row = 0;
    int last_wr_row = -1, last_wr_col = -1;

    function automatic logic [7:0] rd(ref logic [7:0] m [int], input int a);
        return m.exists(a) ? m[a] : 8'h00;
    endfunction

    // Per-clock model: sample outputs at the falling edge, check, drive data.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(!dram_we_n && !dram_oe_n), "R2 we/oe exclusive", {dram_we_n, dram_oe_n}, 2'b11);
            if (prev_ras && !dram_ras_n) begin
                chk(dram_addr == prev_addr, "R1 row setup", dram_addr, prev_addr);
                chk(cyc - ras_fall_cyc >= RC, "R3 row cycle gap", cyc - ras_fall_cyc, RC);
                chk(cyc - ras_rise_cyc >= RP, "R10 precharge", cyc - ras_rise_cyc, RP);
                ras_fall_cyc = cyc;
                open_row = dram_addr;
                cas_seen = 0;
                ras_falls++;
            end
            if (!prev_ras && dram_ras_n) begin
                ras_rise_cyc = cyc;
                if (!cas_seen) begin
                    chk(int'(open_row) == exp_ref_row, "R8 refresh row order", open_row, exp_ref_row);
                    chk((cyc - last_ref_cyc <= REFC + SLACK) && (cyc - last_ref_cyc >= REFC - SLACK),
                        "R8 refresh interval", cyc - last_ref_cyc, REFC);
                    last_ref_cyc = cyc;
                    exp_ref_row = (exp_ref_row + 1) % 512;
                    nref++;
                end
            end
            if (prev_cas && !dram_cas_n) begin
                chk(!dram_ras_n, "R6 column strobe inside open row", dram_ras_n, 0);
                chk(dram_addr == prev_addr, "R1 column setup", dram_addr, prev_addr);
                chk(cyc - cas_fall_cyc >= PC, "R5 column cycle gap", cyc - cas_fall_cyc, PC);
                cas_fall_cyc = cyc;
                cas_seen = 1;
                if (!dram_we_n) begin
                    chk(!prev_we && dram_dq_oe && dram_oe_n, "R7 early write setup",
                        {prev_we, dram_dq_oe, dram_oe_n}, 3'b011);
                    dmem[{open_row, dram_addr}] = dram_dq_out;
                    last_wr_row = open_row;
                    last_wr_col = dram_addr;
                end
            end
            if (!dram_cas_n && !prev_cas && !dram_we_n)
                chk(dram_dq_oe && dram_oe_n, "R7 write data held", {dram_dq_oe, dram_oe_n}, 2'b11);
            if (!dram_ras_n && !cas_seen)
                chk(!req_ready, "R9 no request taken during row-only phase", req_ready, 0);
            if (rsp_valid) begin
                if (exp_q.size() == 0) chk(0, "R4 unexpected response", rsp_rdata, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata == e, "R4 read data", rsp_rdata, e);
                end
            end
            // Drive read data; corrupt until both access times have run.
            if (!dram_ras_n && !dram_cas_n && !dram_oe_n) begin
                logic [7:0] v;
                v = rd(dmem, int'({open_row, dram_addr}));
                if ((cyc + 1 - ras_fall_cyc >= RAC) && (cyc + 1 - cas_fall_cyc >= CAC))
                    dram_dq_in = v;
                else
                    dram_dq_in = v ^ 8'hFF;
            end else begin
                dram_dq_in = 8'hEE;
            end
        end
        prev_ras  = dram_ras_n;
        prev_cas  = dram_cas_n;
        prev_we   = dram_we_n;
        prev_addr = dram_addr;
    end

    // Issue one request; called and returns at a falling edge.
    task automatic do_req(input bit wr, input logic [17:0] a, input logic [7:0] d);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (wr) shadow[int'(a)] = d;
        else    exp_q.push_back(rd(shadow, int'(a)));
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic wait_refresh();
        int n0;
        n0 = nref;
        while (nref == n0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int r0;
        int seed;
        repeat (5) @(negedge clk);
        // Reset state (R2)
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe,
            "R2 reset pin levels", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe}, 5'b11110);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready, "R2 ready after reset", req_ready, 1);

        // R11 address split on a single write
        do_req(1, 18'h2A5C3, 8'h3C);
        drain();
        chk(last_wr_row == 18'h2A5C3 >> 9, "R11 row half", last_wr_row, 18'h2A5C3 >> 9);
        chk(last_wr_col == (18'h2A5C3 & 18'h1FF), "R11 column half", last_wr_col, 18'h2A5C3 & 18'h1FF);

        // Writes over several rows then read back (R4, R7)
        for (int i = 0; i < 8; i++) do_req(1, 18'((i * 9337 + 71) % 262144), 8'((i * 37 + 11) & 8'h7F));
        for (int i = 0; i < 8; i++) do_req(0, 18'((i * 9337 + 71) % 262144), 8'h00);
        drain();

        // Page hits: one row strobe for the whole group (R6)
        wait_refresh();
        r0 = ras_falls;
        for (int i = 0; i < 4; i++) do_req(1, {9'd77, 9'(i * 5)}, 8'(8'h40 + i));
        for (int i = 0; i < 4; i++) do_req(0, {9'd77, 9'(i * 5)}, 8'h00);
        drain();
        chk(ras_falls - r0 == 1, "R6 page hits share one row open", ras_falls - r0, 1);

        // Row misses: every request opens a row (R3, R10)
        wait_refresh();
        r0 = ras_falls;
        for (int i = 0; i < 6; i++) do_req(0, {(i % 2) ? 9'd77 : 9'd300, 9'd5}, 8'h00);
        drain();
        chk(ras_falls - r0 == 6, "R10 each miss reopens a row", ras_falls - r0, 6);

        // Mixed stream across refreshes (R8, R9, R4)
        seed = 12345;
        for (int i = 0; i < 300; i++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            do_req(seed[4], {7'd0, seed[6:5], seed[15:7]}, 8'(seed[23:16]));
        end
        drain();
        r0 = nref;
        repeat (3 * REFC) @(negedge clk);
        chk(nref - r0 >= 2, "R8 refresh keeps running while idle", nref - r0, 3);
        chk(exp_q.size() == 0, "R4 all responses returned", exp_q.size(), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule